// File: doc/BRIEF.md
# PAL Raster Timing and Scan Address Generator

This block turns a pixel clock into the timing of an interlaced 625-line raster. It drives a line sync pulse, a field sync pulse, a combined blanking flag, a field-parity flag and an active-pixel flag. In step with that timing it produces the linear read address of the video-memory pixel to show. The visible window is a square image of `ACTIVE_W` columns by `FRAME_LINES - 2*VBLANK_LINES` rows (575 by 575 with the default parameters). The first field scans the even image rows and the second field scans the odd rows, so one frame covers the whole stored image. Every waveform is decoded from a column counter and a line counter. No stored waveform table is used.

An optional external sync input can take over line timing. A lock detector watches rising edges on that input. Once the edges arrive at exactly one line period for long enough, the detector declares lock. While locked, each incoming edge forces the generated column counter onto it. The memory address follows the same strobes that the timing produces. It reloads to the start of the field's first image row every time vertical blanking ends, so an address made wrong by a forced realignment is corrected by the next field. A low `en` freezes the raster and the address for the cycles it is held low.

Top module: `pal_scan_gen`

## Requirements
- R1: After reset, and before the first enabled clock, the outputs are: `hSync`=1, `vSync`=1, `blank`=1, `field`=0, `active`=0, `extLocked`=0. This is column 0 of line 0.
- R2: Each line lasts `LINE_CLKS` enabled clocks. `hSync` is 1 for columns 0 to `HSYNC_CLKS-1` and 0 for every other column.
- R3: Lines 0 to ceil(`FRAME_LINES`/2)-1 of a frame form field 0 (`field`=0). The remaining lines form field 1 (`field`=1). `vSync` is 1 during the first `VSYNC_LINES` lines of each field.
- R4: `blank` is 1 during the first `VBLANK_LINES` lines of each field. It is also 1 in every column outside `HACT_START` to `HACT_START+ACTIVE_W-1`. `active` is the inverse of `blank`.
- R5: While `active`=1, `scanAddr` = row*`ACTIVE_W` + (column-`HACT_START`). Here row = 2*(line within field - `VBLANK_LINES`) + `field`, so field 0 shows even image rows and field 1 shows odd rows.
- R6: While `en`=0, the counters, the address and all timing outputs hold their values.
- R7: A rising edge is a cycle with `extSync`=1 after a cycle with `extSync`=0. `extLocked` becomes 1 in the cycle after the third consecutive rising edge when each edge follows the previous one by exactly `LINE_CLKS` clocks.
- R8: `extLocked` falls `LINE_CLKS+1` clocks after the last rising edge if no new edge has come. A rising edge at any other spacing restarts the count at one edge, so evenly mis-spaced pulses never lock.
- R9: While `extLocked`=1 and `en`=1, a rising edge makes that cycle column 0 of the line: the next cycle is column 1 and shows `hSync`=1. The line number is left unchanged.
- R10: At the end of the last blanked line at the top of each field, `scanAddr` reloads to the field's first row: 0 for field 0 and `ACTIVE_W` for field 1. This happens even after a realignment has disturbed the address, so R5 holds again from the following field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low freezes the raster |
| extSync | input | 1 | External line sync, synchronous to clk, active high |
| hSync | output | 1 | Line sync pulse |
| vSync | output | 1 | Field sync pulse |
| blank | output | 1 | Combined horizontal and vertical blanking |
| field | output | 1 | Field parity: 0 first field, 1 second field |
| active | output | 1 | Current pixel lies in the visible window |
| scanAddr | output | ADDR_W | Video memory read address of the current pixel |
| extLocked | output | 1 | External sync is present and trusted |

## Verification
The bound checker watches, on every cycle, four things. Both sync pulses must fall inside blanking. Field parity may change only inside field sync. The address must advance by exactly one between adjacent enabled active pixels, and the raster must freeze while `en` is low. The checker also confirms that lock rises only right after an edge, and that a locked edge lands the raster on a sync column. Several behaviours can only be shown by the bench's scenarios, because each needs a full positional model of the raster. These are the exact row interleave and the reload value at each field start. They also include the edge count and spacing needed for lock, the cycle in which lock is lost, and the return of correct addresses one field after a forced realignment.

// File: rtl/pal_scan_pkg.sv
package pal_scan_pkg;

  // Strobes sent from the raster control to the address datapath.
  typedef struct packed {
    logic step;      // an enabled visible pixel is consumed this cycle
    logic rowSkip;   // that pixel is the last of its row: jump over the other field's row
    logic loadBase;  // vertical blanking ends: reload the field's first row
    logic baseOdd;   // the field about to start is the second field
  } scan_strobe_t;

endpackage

// File: rtl/pal_sync_lock.sv
module pal_sync_lock #(
  parameter int LINE_CLKS   = 736,
  parameter int LOCK_PULSES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic extSync,
  output logic extEdge,
  output logic locked
);
  localparam int G_W = $clog2(LINE_CLKS + 2);
  localparam int R_W = $clog2(LOCK_PULSES + 1);
  localparam logic [G_W-1:0] GAP_LINE = G_W'(LINE_CLKS);
  localparam logic [G_W-1:0] GAP_SAT  = G_W'(LINE_CLKS + 1);
  localparam logic [R_W-1:0] RUN_FULL = R_W'(LOCK_PULSES);

  logic           extPrev;
  logic [G_W-1:0] gapCnt;
  logic [R_W-1:0] runCnt;

  assign extEdge = extSync & ~extPrev;
  assign locked  = (runCnt == RUN_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      extPrev <= 1'b0;
      gapCnt  <= GAP_SAT;
      runCnt  <= '0;
    end else begin
      extPrev <= extSync;
      if (extEdge) begin
        gapCnt <= G_W'(1);
        if (runCnt != '0 && gapCnt == GAP_LINE)
          runCnt <= (runCnt == RUN_FULL) ? RUN_FULL : runCnt + R_W'(1);
        else
          runCnt <= R_W'(1);
      end else begin
        if (gapCnt != GAP_SAT) gapCnt <= gapCnt + G_W'(1);
        if (gapCnt == GAP_LINE) runCnt <= '0;
      end
    end
  end
endmodule

// File: rtl/pal_raster_ctrl.sv
module pal_raster_ctrl
  import pal_scan_pkg::*;
#(
  parameter int LINE_CLKS    = 736,
  parameter int HSYNC_CLKS   = 54,
  parameter int HACT_START   = 140,
  parameter int ACTIVE_W     = 575,
  parameter int FRAME_LINES  = 625,
  parameter int VSYNC_LINES  = 3,
  parameter int VBLANK_LINES = 25
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         realign,
  output scan_strobe_t strb,
  output logic         hSync,
  output logic         vSync,
  output logic         blank,
  output logic         field,
  output logic         active
);
  localparam int H_W          = $clog2(LINE_CLKS);
  localparam int V_W          = $clog2(FRAME_LINES);
  localparam int FIELD0_LINES = (FRAME_LINES + 1) / 2;

  localparam logic [H_W-1:0] H_LAST     = H_W'(LINE_CLKS - 1);
  localparam logic [H_W-1:0] H_SYNC_END = H_W'(HSYNC_CLKS);
  localparam logic [H_W-1:0] H_ACT0     = H_W'(HACT_START);
  localparam logic [H_W-1:0] H_ACT_LAST = H_W'(HACT_START + ACTIVE_W - 1);
  localparam logic [V_W-1:0] V_LAST     = V_W'(FRAME_LINES - 1);
  localparam logic [V_W-1:0] V_F1_FIRST = V_W'(FIELD0_LINES);
  localparam logic [V_W-1:0] V_SYNC_END = V_W'(VSYNC_LINES);
  localparam logic [V_W-1:0] V_BLK_END  = V_W'(VBLANK_LINES);
  localparam logic [V_W-1:0] V_BLK_LAST = V_W'(VBLANK_LINES - 1);

  logic [H_W-1:0] hCnt;
  logic [V_W-1:0] vCnt;
  logic [V_W-1:0] lineInField;
  logic           lineEnd, frameEnd, hBlank, vBlank;

  assign lineEnd  = (hCnt == H_LAST);
  assign frameEnd = (vCnt == V_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (en) begin
      if (realign) begin
        hCnt <= H_W'(1);
      end else if (lineEnd) begin
        hCnt <= '0;
        vCnt <= frameEnd ? '0 : vCnt + V_W'(1);
      end else begin
        hCnt <= hCnt + H_W'(1);
      end
    end
  end

  always_comb begin
    field       = (vCnt >= V_F1_FIRST);
    lineInField = field ? (vCnt - V_F1_FIRST) : vCnt;
    hSync       = (hCnt < H_SYNC_END);
    vSync       = (lineInField < V_SYNC_END);
    hBlank      = (hCnt < H_ACT0) || (hCnt > H_ACT_LAST);
    vBlank      = (lineInField < V_BLK_END);
    blank       = hBlank | vBlank;
    active      = ~blank;
  end

  always_comb begin
    strb.step     = en & active;
    strb.rowSkip  = en & active & (hCnt == H_ACT_LAST);
    strb.loadBase = en & ~realign & lineEnd & (lineInField == V_BLK_LAST);
    strb.baseOdd  = field;
  end
endmodule

// File: rtl/pal_addr_path.sv
module pal_addr_path
  import pal_scan_pkg::*;
#(
  parameter int ACTIVE_W = 575,
  parameter int ADDR_W   = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  scan_strobe_t      strb,
  output logic [ADDR_W-1:0] scanAddr
);
  localparam logic [ADDR_W-1:0] ROW_STRIDE = ADDR_W'(ACTIVE_W);
  localparam logic [ADDR_W-1:0] ONE        = ADDR_W'(1);

  logic [ADDR_W-1:0] addrQ;
  assign scanAddr = addrQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ <= '0;
    end else if (strb.loadBase) begin
      addrQ <= strb.baseOdd ? ROW_STRIDE : '0;
    end else if (strb.step) begin
      addrQ <= addrQ + ONE + (strb.rowSkip ? ROW_STRIDE : '0);
    end
  end
endmodule

// File: rtl/pal_scan_gen.sv
module pal_scan_gen
  import pal_scan_pkg::*;
#(
  parameter int LINE_CLKS    = 736,
  parameter int HSYNC_CLKS   = 54,
  parameter int HACT_START   = 140,
  parameter int ACTIVE_W     = 575,
  parameter int FRAME_LINES  = 625,
  parameter int VSYNC_LINES  = 3,
  parameter int VBLANK_LINES = 25,
  parameter int LOCK_PULSES  = 3,
  localparam int ACTIVE_H    = FRAME_LINES - 2 * VBLANK_LINES,
  localparam int ADDR_W      = $clog2(ACTIVE_W * ACTIVE_H)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              extSync,
  output logic              hSync,
  output logic              vSync,
  output logic              blank,
  output logic              field,
  output logic              active,
  output logic [ADDR_W-1:0] scanAddr,
  output logic              extLocked
);
  scan_strobe_t strb;
  logic         extEdge;
  logic         realign;

  assign realign = en & extLocked & extEdge;

  pal_sync_lock #(
    .LINE_CLKS  (LINE_CLKS),
    .LOCK_PULSES(LOCK_PULSES)
  ) u_lock (
    .clk    (clk),
    .rst    (rst),
    .extSync(extSync),
    .extEdge(extEdge),
    .locked (extLocked)
  );

  pal_raster_ctrl #(
    .LINE_CLKS   (LINE_CLKS),
    .HSYNC_CLKS  (HSYNC_CLKS),
    .HACT_START  (HACT_START),
    .ACTIVE_W    (ACTIVE_W),
    .FRAME_LINES (FRAME_LINES),
    .VSYNC_LINES (VSYNC_LINES),
    .VBLANK_LINES(VBLANK_LINES)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .realign(realign),
    .strb   (strb),
    .hSync  (hSync),
    .vSync  (vSync),
    .blank  (blank),
    .field  (field),
    .active (active)
  );

  pal_addr_path #(
    .ACTIVE_W(ACTIVE_W),
    .ADDR_W  (ADDR_W)
  ) u_addr (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .scanAddr(scanAddr)
  );
endmodule

// File: rtl/pal_scan_checker.sv
module pal_scan_checker #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              extSync,
  input logic              hSync,
  input logic              vSync,
  input logic              blank,
  input logic              field,
  input logic              active,
  input logic [ADDR_W-1:0] scanAddr,
  input logic              extLocked
);
  // R2 / R4: line sync only inside blanking
  a_r2_hsync_blanked: assert property (@(posedge clk) disable iff (rst)
    hSync |-> blank);

  // R3 / R4: field sync only inside blanking
  a_r3_vsync_blanked: assert property (@(posedge clk) disable iff (rst)
    vSync |-> blank);

  // R3: parity changes only at the start of a field sync
  a_r3_field_edge: assert property (@(posedge clk) disable iff (rst)
    !$stable(field) |-> (vSync && blank));

  // R5: adjacent enabled visible pixels read consecutive addresses
  a_r5_addr_step: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && $past(active) && active) |-> (scanAddr == $past(scanAddr) + 1'b1));

  // R6: frozen raster while disabled
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> ($stable(scanAddr) && $stable(hSync) && $stable(blank) && $stable(field)));

  // R7: lock rises only right after a rising edge
  a_r7_lock_on_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(extLocked) |-> ($past(extSync) && !$past(extSync, 2)));

  // R9: a locked edge puts the raster into its sync columns
  a_r9_realign_sync: assert property (@(posedge clk) disable iff (rst)
    ($past(extLocked) && $past(en) && $past(extSync) && !$past(extSync, 2)) |-> hSync);
endmodule

bind pal_scan_gen pal_scan_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .extSync  (extSync),
  .hSync    (hSync),
  .vSync    (vSync),
  .blank    (blank),
  .field    (field),
  .active   (active),
  .scanAddr (scanAddr),
  .extLocked(extLocked)
);

// File: tb/tb_pal_scan_gen.sv
module tb_pal_scan_gen;
  localparam int CLK_PERIOD = 10;
  localparam int LINE  = 20;
  localparam int HS    = 3;
  localparam int HA    = 6;
  localparam int W     = 10;
  localparam int FRAME = 15;
  localparam int VS    = 1;
  localparam int VB    = 2;
  localparam int F0    = (FRAME + 1) / 2;
  localparam int AW    = $clog2(W * (FRAME - 2 * VB));

  logic clk = 1'b0;
  logic rst, en, extSync;
  logic hSync, vSync, blank, field, active, extLocked;
  logic [AW-1:0] scanAddr;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  int mh, mv;
  bit trust, prevEn, phase2;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pal_scan_gen #(
    .LINE_CLKS(LINE), .HSYNC_CLKS(HS), .HACT_START(HA), .ACTIVE_W(W),
    .FRAME_LINES(FRAME), .VSYNC_LINES(VS), .VBLANK_LINES(VB), .LOCK_PULSES(3)
  ) dut (
    .clk(clk), .rst(rst), .en(en), .extSync(extSync),
    .hSync(hSync), .vSync(vSync), .blank(blank), .field(field),
    .active(active), .scanAddr(scanAddr), .extLocked(extLocked)
  );

  function automatic int fieldOf(int v); return (v >= F0) ? 1 : 0; endfunction
  function automatic int lineIn(int v);  return (v >= F0) ? v - F0 : v; endfunction
  function automatic int expBlank(int h, int v);
    return (lineIn(v) < VB || h < HA || h >= HA + W) ? 1 : 0;
  endfunction
  function automatic int expAddr(int h, int v);
    return (2 * (lineIn(v) - VB) + fieldOf(v)) * W + (h - HA);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    string t2, t3, t4, t5;
    int eb;
    eb = expBlank(mh, mv);
    t2 = prevEn ? "R2" : "R6";
    t3 = prevEn ? "R3" : "R6";
    t4 = prevEn ? "R4" : "R6";
    t5 = !prevEn ? "R6" : (phase2 ? "R10" : "R5");
    chk(int'(hSync) == ((mh < HS) ? 1 : 0), t2, "hSync", int'(hSync), (mh < HS) ? 1 : 0);
    chk(int'(vSync) == ((lineIn(mv) < VS) ? 1 : 0), t3, "vSync", int'(vSync), (lineIn(mv) < VS) ? 1 : 0);
    chk(int'(field) == fieldOf(mv), t3, "field", int'(field), fieldOf(mv));
    chk(int'(blank) == eb, t4, "blank", int'(blank), eb);
    chk(int'(active) == 1 - eb, t4, "active", int'(active), 1 - eb);
    if (eb == 0 && trust)
      chk(int'(scanAddr) == expAddr(mh, mv), t5, "scanAddr", int'(scanAddr), expAddr(mh, mv));
  endtask

  // drive at negedge, advance model at posedge, compare at next negedge
  task automatic step(input bit enV, input bit extV, input bit rlExp);
    en = enV;
    extSync = extV;
    @(posedge clk);
    if (enV) begin
      if (rlExp) begin
        mh = 1;
      end else if (mh == LINE - 1) begin
        mh = 0;
        mv = (mv == FRAME - 1) ? 0 : mv + 1;
      end else begin
        mh++;
      end
      if (mh == 0 && lineIn(mv) == VB) trust = 1'b1;
    end
    prevEn = enV;
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd4711);
    rst = 1'b1; en = 1'b0; extSync = 1'b0;
    mh = 0; mv = 0; trust = 1'b1; prevEn = 1'b1; phase2 = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(hSync == 1'b1 && vSync == 1'b1 && blank == 1'b1 && field == 1'b0 && active == 1'b0,
        "R1", "reset outputs", {hSync, vSync, blank, field, active}, 5'b11100);
    chk(extLocked == 1'b0, "R1", "extLocked", int'(extLocked), 0);

    // R2..R5: one fully enabled frame, then randomly gated frames
    for (int i = 0; i < FRAME * LINE; i++) step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3 * FRAME * LINE; i++) step(($urandom % 4) != 0, 1'b0, 1'b0);
    // R6: long freeze
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 7; i++) step(1'b1, 1'b0, 1'b0);

    // R7: three correctly spaced edges lock
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 1'b1, 1'b0);
      chk(int'(extLocked) == ((k == 2) ? 1 : 0), "R7", "extLocked after edge",
          int'(extLocked), (k == 2) ? 1 : 0);
      for (int j = 0; j < LINE - 1; j++) step(1'b1, 1'b0, 1'b0);
    end
    // R9: locked edge realigns raster to column 0 on the edge cycle
    phase2 = 1'b1;
    trust = 1'b0;
    step(1'b1, 1'b1, 1'b1);
    chk(hSync == 1'b1 && blank == 1'b1, "R9", "hSync after realign", int'(hSync), 1);
    for (int j = 0; j < LINE - 1; j++) step(1'b1, 1'b0, 1'b0);
    // R10: aligned pulses continue; address comparison resumes after field reload
    for (int k = 0; k < 2 * FRAME; k++) begin
      step(1'b1, 1'b1, 1'b1);
      chk(hSync == 1'b1, "R9", "hSync on aligned edge", int'(hSync), 1);
      for (int j = 0; j < LINE - 1; j++) step(1'b1, 1'b0, 1'b0);
    end
    chk(trust == 1'b1, "R10", "field reload seen", int'(trust), 1);
    // R8: loss after LINE+1 clocks without an edge
    step(1'b1, 1'b1, 1'b1);
    for (int j = 0; j < LINE - 1; j++) step(1'b1, 1'b0, 1'b0);
    chk(extLocked == 1'b1, "R8", "extLocked at gap LINE", int'(extLocked), 1);
    step(1'b1, 1'b0, 1'b0);
    chk(extLocked == 1'b0, "R8", "extLocked at gap LINE+1", int'(extLocked), 0);
    // R8: edges one clock short never lock
    for (int k = 0; k < 6; k++) begin
      step(1'b1, 1'b1, 1'b0);
      chk(extLocked == 1'b0, "R8", "mis-spaced edges", int'(extLocked), 0);
      for (int j = 0; j < LINE - 2; j++) step(1'b1, 1'b0, 1'b0);
    end
    for (int i = 0; i < FRAME * LINE; i++) step(1'b1, 1'b0, 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule